// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

A single-port synchronous memory with a zero-turnaround command protocol. Each enabled rising clock edge carries exactly one command: begin a read, begin a write, deselect, or continue the current burst. Reads and writes can follow each other in any mix without idle cycles, because write data is taken two enabled edges after its command while read data leaves one enabled edge after its command, so the two data paths never compete.

A command starts only when the load strobe is low and all three chip selects are active. With the load strobe high, the core continues the previous burst at the next address, which it computes from the loaded start address in either sequential or bit-flip (interleaved) order. A clock-enable input freezes the whole core, and a sleep input puts it into a frozen, output-silent state after two edges and restores it after two wake-up edges, keeping all stored data and pipeline contents. A read of a location whose write is still in flight returns the new bytes by forwarding.

Top module: `ztsram_core`

## Requirements
- R1: With `hold` low, `ld_n` low, `sel_a_n` low, `sel_b` high and `sel_c_n` low, `wr_n` high begins a read; its data appears on `rdata` with `rvalid` high after the next enabled edge.
- R2: With `ld_n` low and any chip select inactive, the edge is a deselect: no array write, and `rvalid` is low after the following enabled edge.
- R3: With `ld_n` high after a read or write start, the address advances; with `burst_mode` low the low two address bits follow start+0, +1, +2, +3 modulo 4.
- R4: With `burst_mode` high the low two address bits follow start XOR 0, 1, 2, 3.
- R5: Write data on `wdata` is taken at the second enabled edge after the write command (begin or continue); bit `i` of `lane_wr_n` low enables byte lane `i` (`wdata[8i+7:8i]`), and lanes left high keep their old contents.
- R6: A write command with every bit of `lane_wr_n` high changes no location.
- R7: A read issued one enabled edge after a write to the same address returns the enabled bytes of that write's data.
- R8: While `hold` is high, every input except `out_en_n` and `sleep` is ignored and `rvalid`/`rdata` keep their values.
- R9: With `sleep` high, commands at the first two edges still execute; from then until two edges after `sleep` falls, commands are ignored and `rvalid` is low; all data and pipeline contents are kept.
- R10: `rvalid` is high only when `out_en_n` is low and the previous enabled edge carried a read; otherwise `rdata` is zero.
- R11: A continue (`ld_n` high) after a deselect is another deselect, regardless of `wr_n` and `lane_wr_n`.
- R12: After reset `rvalid` is low and the core is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | High freezes the core (clock enable, active low) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low loads a new command, high continues |
| wr_n | input | 1 | Low write, high read at command start |
| lane_wr_n | input | LANES | Per-byte write enables, active low |
| burst_mode | input | 1 | 0 sequential, 1 interleaved burst order |
| addr | input | ADDR_W | Start address |
| wdata | input | LANES*LANE_W | Write data, two enabled edges after command |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The hardest situation to reach is the one where stored state must survive a freeze: a read result sitting in the output register while sleep masks it, with a write command offered during the frozen edges. The stimulus launches a read on the same edge that sleep rises, drives a full-lane write with fresh data through the frozen edges, then releases sleep and checks that the old read result reappears exactly two edges later and that the targeted word is unchanged. Forwarding is reached by placing a read one edge after a partial-lane write, so the array and the data input must be merged lane by lane.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ztsram_cmd.sv
module ztsram_cmd
  import ztsram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              ld_n,
  input  logic              wr_n,
  input  logic              burst_mode,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op,
  output logic [ADDR_W-1:0] op_addr
);
  op_e               kind_q, kind_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic [BURST_W-1:0] low_bits;

  always_comb begin
    kind_d = kind_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (!ld_n) begin
      kind_d = sel_ok ? (wr_n ? OP_READ : OP_WRITE) : OP_IDLE;
      base_d = addr;
      cnt_d  = '0;
    end else if (kind_q != OP_IDLE) begin
      cnt_d = cnt_q + 1'b1;
    end
    low_bits = burst_mode ? (base_d[BURST_W-1:0] ^ cnt_d)
                          : (base_d[BURST_W-1:0] + cnt_d);
    op      = kind_d;
    op_addr = {base_d[ADDR_W-1:BURST_W], low_bits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (adv) begin
      kind_q <= kind_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R11
  desel_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ld_n && kind_q == OP_IDLE) |=> (kind_q == OP_IDLE));
endmodule

// File: rtl/ztsram_wpipe.sv
module ztsram_wpipe #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              issue_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_en,
  output logic              commit_v,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [LANES-1:0]  commit_mask
);
  logic              s1_v_q, s1_v_d, s2_v_q, s2_v_d;
  logic [ADDR_W-1:0] s1_a_q, s1_a_d, s2_a_q, s2_a_d;
  logic [LANES-1:0]  s1_m_q, s1_m_d, s2_m_q, s2_m_d;

  always_comb begin
    s1_v_d = s1_v_q; s1_a_d = s1_a_q; s1_m_d = s1_m_q;
    s2_v_d = s2_v_q; s2_a_d = s2_a_q; s2_m_d = s2_m_q;
    if (adv) begin
      s1_v_d = issue_wr;
      s1_a_d = addr;
      s1_m_d = lane_en;
      s2_v_d = s1_v_q;
      s2_a_d = s1_a_q;
      s2_m_d = s1_m_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0; s1_a_q <= '0; s1_m_q <= '0;
      s2_v_q <= 1'b0; s2_a_q <= '0; s2_m_q <= '0;
    end else begin
      s1_v_q <= s1_v_d; s1_a_q <= s1_a_d; s1_m_q <= s1_m_d;
      s2_v_q <= s2_v_d; s2_a_q <= s2_a_d; s2_m_q <= s2_m_d;
    end
  end

  assign commit_v    = s2_v_q;
  assign commit_addr = s2_a_q;
  assign commit_mask = s2_m_q;

  // R5
  wr_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_v_q) |=> (s2_v_q && s2_a_q == $past(s1_a_q)));
endmodule

// File: rtl/ztsram_array.sv
module ztsram_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              hit;

  assign hit = we && (wr_addr == rd_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign rd_data[l*LANE_W +: LANE_W] = (hit && wr_mask[l])
      ? wr_data[l*LANE_W +: LANE_W] : mem[rd_addr][l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_mask[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  // R6
  abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_mask == '0) |=> (mem[$past(wr_addr)] == $past(mem[wr_addr])));
endmodule

// File: rtl/ztsram_core.sv
module ztsram_core
  import ztsram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    ld_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    burst_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        slp_q, slp_d;
  logic              adv, sel_ok;
  op_e               op;
  logic [ADDR_W-1:0] op_addr;
  logic              c_v;
  logic [ADDR_W-1:0] c_addr;
  logic [LANES-1:0]  c_mask;
  logic [DATA_W-1:0] arr_rd;
  logic              rd1_v_q, rd1_v_d, q_v_q, q_v_d;
  logic [ADDR_W-1:0] rd1_a_q, rd1_a_d;
  logic [DATA_W-1:0] q_data_q, q_data_d;

  assign adv    = !hold && !slp_q[1];
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  ztsram_cmd #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) cmd_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .sel_ok(sel_ok), .ld_n(ld_n),
    .wr_n(wr_n), .burst_mode(burst_mode), .addr(addr), .op(op), .op_addr(op_addr)
  );

  ztsram_wpipe #(.ADDR_W(ADDR_W), .LANES(LANES)) wpipe_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .issue_wr(op == OP_WRITE),
    .addr(op_addr), .lane_en(~lane_wr_n), .commit_v(c_v),
    .commit_addr(c_addr), .commit_mask(c_mask)
  );

  ztsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .rst_n(rst_n), .we(adv && c_v), .wr_addr(c_addr),
    .wr_mask(c_mask), .wr_data(wdata), .rd_addr(rd1_a_q), .rd_data(arr_rd)
  );

  always_comb begin
    slp_d    = {slp_q[0], sleep};
    rd1_v_d  = rd1_v_q;
    rd1_a_d  = rd1_a_q;
    q_v_d    = q_v_q;
    q_data_d = q_data_q;
    if (adv) begin
      rd1_v_d  = (op == OP_READ);
      rd1_a_d  = op_addr;
      q_v_d    = rd1_v_q;
      q_data_d = arr_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_q    <= '0;
      rd1_v_q  <= 1'b0;
      rd1_a_q  <= '0;
      q_v_q    <= 1'b0;
      q_data_q <= '0;
    end else begin
      slp_q    <= slp_d;
      rd1_v_q  <= rd1_v_d;
      rd1_a_q  <= rd1_a_d;
      q_v_q    <= q_v_d;
      q_data_q <= q_data_d;
    end
  end

  assign rvalid = q_v_q && !out_en_n && !slp_q[1];
  assign rdata  = rvalid ? q_data_q : '0;

  // R1
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rd1_v_q) |=> q_v_q);
  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv) |=> ($stable(q_v_q) && $stable(q_data_q) && $stable(rd1_v_q)));
  // R9
  sleep_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slp_q[1]) |-> !rvalid);
endmodule

// File: tb/ztsram_core_tb.sv
module ztsram_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, hold, sel_a_n, sel_b, sel_c_n, ld_n, wr_n;
  logic [1:0]  lane_wr_n;
  logic        burst_mode, out_en_n, sleep;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata;
  logic        rvalid;
  int          nchk = 0;
  int          nfail = 0;

  always #2 clk = ~clk;

  ztsram_core dut_i (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .ld_n(ld_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .burst_mode(burst_mode), .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
    .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
  );

  typedef struct packed {
    logic        sel; logic ld; logic wr; logic [1:0] ln; logic [3:0] a;
    logic [15:0] wd; logic ev; logic [15:0] ed;
  } vec_t;

  // tags per row: R5 writes, R1 reads, R7 row 6, R2 rows 6/9, R6 rows 7-9, R11 rows 10-13
  localparam vec_t VEC [0:13] = '{
    '{1'b1, 1'b0, 1'b0, 2'b00, 4'd4, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 2'b00, 4'd5, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 2'b11, 4'd4, 16'h1111, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 2'b11, 4'd5, 16'h2222, 1'b1, 16'h1111},
    '{1'b1, 1'b0, 1'b0, 2'b10, 4'd5, 16'h0000, 1'b1, 16'h2222},
    '{1'b1, 1'b0, 1'b1, 2'b11, 4'd5, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'hABCD, 1'b1, 16'h22CD},
    '{1'b1, 1'b0, 1'b0, 2'b11, 4'd5, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 2'b11, 4'd5, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'hFFFF, 1'b1, 16'h22CD},
    '{1'b0, 1'b1, 1'b0, 2'b00, 4'd5, 16'h5555, 1'b0, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 2'b00, 4'd5, 16'h5555, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 2'b11, 4'd5, 16'h5555, 1'b0, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'h5555, 1'b1, 16'h22CD}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic s, input logic l, input logic w,
                       input logic [1:0] ln, input logic [3:0] a, input logic [15:0] wd);
    sel_a_n = 1'b0; sel_b = s; sel_c_n = 1'b0;
    ld_n = l; wr_n = w; lane_wr_n = ln; addr = a; wdata = wd;
  endtask

  task automatic chk(input string req, input logic ev, input logic [15:0] ed);
    nchk++;
    if (rvalid !== ev || rdata !== ed) begin
      nfail++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               req, rvalid, rdata, ev, ed);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hold = 1'b0; out_en_n = 1'b0; sleep = 1'b0; burst_mode = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 2'b11, 4'd0, 16'h0);
    repeat (3) step();
    rst_n = 1'b1;
    chk("R12 reset", 1'b0, 16'h0);
    step();
    chk("R12 deselected after reset", 1'b0, 16'h0);

    for (int i = 0; i < 14; i++) begin
      drive(VEC[i].sel, VEC[i].ld, VEC[i].wr, VEC[i].ln, VEC[i].a, VEC[i].wd);
      step();
      chk($sformatf("table R1 R2 R5 R6 R7 R11 row %0d", i), VEC[i].ev, VEC[i].ed);
    end

    // R8 hold freezes everything
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd4, 16'h0); step();
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd5, 16'h0); step();
    chk("R8 before hold", 1'b1, 16'h1111);
    hold = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 4'd4, 16'h9999); step();
    chk("R8 hold 1", 1'b1, 16'h1111);
    step(); step();
    chk("R8 hold 3", 1'b1, 16'h1111);
    hold = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'h0); step();
    chk("R8 pending read after hold", 1'b1, 16'h22CD);
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd4, 16'h0); step();
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'h0); step();
    chk("R8 write ignored under hold", 1'b1, 16'h1111);

    // R9 sleep
    sleep = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd4, 16'h0); step();
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'h0); step();
    chk("R9 output muted in sleep", 1'b0, 16'h0);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 4'd5, 16'h7777);
    step(); step(); step();
    chk("R9 asleep", 1'b0, 16'h0);
    sleep = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'h7777); step();
    chk("R9 wake edge 1", 1'b0, 16'h0);
    step();
    chk("R9 state kept after wake", 1'b1, 16'h1111);
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd5, 16'h0); step();
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'h0); step();
    chk("R9 write ignored while asleep", 1'b1, 16'h22CD);

    // R10 output enable
    out_en_n = 1'b1; #1;
    chk("R10 output disabled", 1'b0, 16'h0);
    out_en_n = 1'b0; #1;
    chk("R10 output enabled", 1'b1, 16'h22CD);

    // R3 sequential burst from 6: 6,7,4,5
    burst_mode = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 4'd6, 16'h0); step();
    drive(1'b1, 1'b1, 1'b0, 2'b00, 4'd0, 16'h0); step();
    drive(1'b1, 1'b1, 1'b0, 2'b00, 4'd0, 16'hB000); step();
    drive(1'b1, 1'b1, 1'b0, 2'b00, 4'd0, 16'hB001); step();
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'hB002); step();
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'hB003); step();
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd6, 16'h0); step();
    drive(1'b1, 1'b1, 1'b1, 2'b11, 4'd0, 16'h0); step();
    chk("R3 burst read 0", 1'b1, 16'hB000);
    step(); chk("R3 burst read 1", 1'b1, 16'hB001);
    step(); chk("R3 burst read 2", 1'b1, 16'hB002);
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'h0); step();
    chk("R3 burst read 3", 1'b1, 16'hB003);
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd4, 16'h0); step();
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'h0); step();
    chk("R3 third beat landed at 4", 1'b1, 16'hB002);

    // R4 interleaved burst from 9: 9,8,11,10
    burst_mode = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 4'd9, 16'h0); step();
    drive(1'b1, 1'b1, 1'b0, 2'b00, 4'd0, 16'h0); step();
    drive(1'b1, 1'b1, 1'b0, 2'b00, 4'd0, 16'hC000); step();
    drive(1'b1, 1'b1, 1'b0, 2'b00, 4'd0, 16'hC001); step();
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'hC002); step();
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'hC003); step();
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd8, 16'h0); step();
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd11, 16'h0); step();
    chk("R4 second beat at 8", 1'b1, 16'hC001);
    drive(1'b1, 1'b0, 1'b1, 2'b11, 4'd10, 16'h0); step();
    chk("R4 third beat at 11", 1'b1, 16'hC002);
    drive(1'b0, 1'b0, 1'b1, 2'b11, 4'd0, 16'h0); step();
    chk("R4 fourth beat at 10", 1'b1, 16'hC003);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule